// File: doc/BRIEF.md
# ALU Status Flag Generator

This block derives and stores the processor status word that sits beside a 16-bit ALU, which can also run at byte width. On every ALU operation the datapath gives it the two operands, the raw result, the carry or borrow out of the top bit of the active width, an operation class and a width select. When the update enable is high, six condition flags are recomputed and registered: carry, auxiliary carry, parity, zero, sign and overflow. The computation follows the selected width.

Three mode flags share the same 16-bit word: single-step, interrupt enable and string direction. They change only through per-flag set and clear strobes. ALU updates never touch them, and the update enable does not gate them either. Bits of the word that carry no flag read back as constants. Downstream logic reads the packed word every cycle.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low and after its release, before any other input takes effect, `flags_o` reads 16'h0002. All flags are clear.
- R2: When `upd_en` is low, the condition flags (bits 0, 2, 4, 6, 7, 11) keep their values, whatever the other ALU inputs are.
- R3: For `op_cls` 0 (add) and 1 (subtract), the carry flag at bit 0 takes the value of `cout`. For subtract, `cout` is the borrow.
- R4: For add and subtract, the auxiliary flag at bit 4 is set when there is a carry or borrow between bit 3 and bit 4. Logic operations leave it unchanged.
- R5: The parity flag at bit 2 is set when `res[7:0]` holds an even number of ones, at either width.
- R6: The zero flag at bit 6 is set when the result is zero within the active width. With `wide`=0, `res[15:8]` is ignored.
- R7: The sign flag at bit 7 copies `res[15]` when `wide`=1 and `res[7]` when `wide`=0.
- R8: The overflow flag at bit 11 is set when a signed add or subtract leaves the range of the active width.
- R9: `op_cls` 2 and 3 are logic operations. They clear the carry and overflow flags.
- R10: The mode flags (single-step at bit 8, interrupt enable at bit 9, direction at bit 10) are indexed 0, 1, 2 in `ctl_set` and `ctl_clr`. A set strobe makes the flag 1 on the next clock. A clear strobe makes it 0, and clear wins over set. With neither strobe the flag holds. `upd_en` has no effect on these flags.
- R11: Bit 1 always reads 1. Bits 3, 5, 12, 13, 14 and 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the source must release it synchronously |
| upd_en | input | 1 | Condition flags load from this cycle's ALU operation |
| op_cls | input | 2 | Operation class: 0 add, 1 subtract, 2 or 3 logic |
| wide | input | 1 | 1 selects 16-bit width, 0 selects 8-bit width |
| opa | input | 16 | First ALU operand |
| opb | input | 16 | Second ALU operand |
| res | input | 16 | Raw ALU result |
| cout | input | 1 | Carry or borrow out of the top bit of the active width |
| ctl_set | input | 3 | Set strobes for the mode flags (0 single-step, 1 interrupt, 2 direction) |
| ctl_clr | input | 3 | Clear strobes for the mode flags, with priority over set |
| flags_o | output | 16 | Registered status word |

## Verification
The bench targets byte-width operations that carry a nonzero upper result byte. A design that reads the full width would report a false nonzero result or take its sign from the wrong bit. It applies signed boundaries such as 0x7F+1, 0x8000-1 and 0xFFFF+1, where a wrong overflow rule or a swapped carry and borrow sense changes bits 0 and 11. It interleaves logic operations with arithmetic, so that a design that clears or recomputes the auxiliary flag on a logic operation is exposed. It also drives simultaneous set and clear strobes while the update enable is low, which shows a wrong priority or a mode flag wrongly gated by the ALU update path.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_LOGX  = 2'd3
  } opc_e;

  // positions inside the status word
  localparam int POS_CF = 0;
  localparam int POS_PF = 2;
  localparam int POS_AF = 4;
  localparam int POS_ZF = 6;
  localparam int POS_SF = 7;
  localparam int POS_TF = 8;
  localparam int POS_IF = 9;
  localparam int POS_DF = 10;
  localparam int POS_OF = 11;

  localparam int NUM_CTL = 3;

  // constant bits: bit 1 reads one, other unused bits read zero
  localparam logic [WORD_W-1:0] FIXED_ONES = 16'h0002;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } cond_t;

endpackage

// File: rtl/flag_eval.sv
module flag_eval
  import alu_flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [1:0]        op_cls,
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  cond_t             cur,
  output cond_t             nxt
);

  localparam int MSB_W = DATA_W - 1;
  localparam int MSB_N = NARROW_W - 1;
  localparam int NIB   = 4;

  // carry (add) or borrow (subtract) arriving at each bit position
  logic [DATA_W-1:0] cin_vec;
  logic              is_logic;
  logic              cin_msb;
  logic              res_msb;
  logic              zro_w;
  logic              zro_n;
  logic              unused_cin;

  assign cin_vec    = opa ^ opb ^ res;
  assign is_logic   = op_cls[1];
  assign unused_cin = ^{cin_vec[DATA_W-2:MSB_N+1], cin_vec[MSB_N-1:NIB+1], cin_vec[NIB-1:0]};

  always_comb begin
    cin_msb = wide ? cin_vec[MSB_W] : cin_vec[MSB_N];
    res_msb = wide ? res[MSB_W]     : res[MSB_N];
    zro_w   = (res == '0);
    zro_n   = (res[NARROW_W-1:0] == '0);
  end

  always_comb begin
    nxt.par = ~^res[NARROW_W-1:0];
    nxt.zro = wide ? zro_w : zro_n;
    nxt.sgn = res_msb;
    if (is_logic) begin
      nxt.cry = 1'b0;
      nxt.ovf = 1'b0;
      nxt.aux = cur.aux;
    end else begin
      nxt.cry = cout;
      nxt.ovf = cin_msb ^ cout;
      nxt.aux = cin_vec[NIB];
    end
  end

endmodule

// File: rtl/ctl_flag_bank.sv
module ctl_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] q_nxt;
  logic [N-1:0] q_en;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_comb begin
      q_en[g]  = set_i[g] | clr_i[g];
      q_nxt[g] = ~clr_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o[g] <= 1'b0;
      else if (q_en[g]) q_o[g] <= q_nxt[g];
    end

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[g] |=> !q_o[g]);
    assert_set_takes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[g] && !clr_i[g]) |=> q_o[g]);
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_i[g] || clr_i[g]) |=> $stable(q_o[g]));
  end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        op_cls,
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  input  logic [2:0]        ctl_set,
  input  logic [2:0]        ctl_clr,
  output logic [15:0]       flags_o
);

  cond_t             cond_q;
  cond_t             cond_calc;
  cond_t             cond_d;
  logic [NUM_CTL-1:0] ctl_q;

  flag_eval #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_eval (
    .op_cls (op_cls),
    .wide   (wide),
    .opa    (opa),
    .opb    (opb),
    .res    (res),
    .cout   (cout),
    .cur    (cond_q),
    .nxt    (cond_calc)
  );

  ctl_flag_bank #(.N(NUM_CTL)) i_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ctl_set),
    .clr_i (ctl_clr),
    .q_o   (ctl_q)
  );

  // next state
  always_comb begin
    cond_d = upd_en ? cond_calc : cond_q;
  end

  // register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cond_q <= '0;
    else if (upd_en) cond_q <= cond_d;
  end

  always_comb begin
    flags_o         = FIXED_ONES;
    flags_o[POS_CF] = cond_q.cry;
    flags_o[POS_PF] = cond_q.par;
    flags_o[POS_AF] = cond_q.aux;
    flags_o[POS_ZF] = cond_q.zro;
    flags_o[POS_SF] = cond_q.sgn;
    flags_o[POS_OF] = cond_q.ovf;
    flags_o[POS_TF] = ctl_q[0];
    flags_o[POS_IF] = ctl_q[1];
    flags_o[POS_DF] = ctl_q[2];
  end

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable({flags_o[POS_OF], flags_o[POS_SF], flags_o[POS_ZF],
                         flags_o[POS_AF], flags_o[POS_PF], flags_o[POS_CF]}));
  assert_carry_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !op_cls[1]) |=> (flags_o[POS_CF] == $past(cout)));
  assert_sign_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (flags_o[POS_SF] == $past(wide ? res[DATA_W-1] : res[NARROW_W-1])));
  assert_logic_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_cls[1]) |=> (!flags_o[POS_CF] && !flags_o[POS_OF]));
  assert_aux_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_cls[1]) |=> $stable(flags_o[POS_AF]));
  assert_parity_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (flags_o[POS_PF] == ($countones($past(res[NARROW_W-1:0])) % 2 == 0)));

endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en;
  logic [1:0]  op_cls;
  logic        wide;
  logic [15:0] opa, opb, res;
  logic        cout;
  logic [2:0]  ctl_set, ctl_clr;
  logic [15:0] flags_o;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [15:0] mdl;
  string       cur_tag;
  bit          done = 0;

  always #5 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls), .wide(wide),
    .opa(opa), .opb(opb), .res(res), .cout(cout),
    .ctl_set(ctl_set), .ctl_clr(ctl_clr), .flags_o(flags_o)
  );

  function automatic string field_req(int b);
    case (b)
      0:       return "R3/R9 carry";
      2:       return "R5 parity";
      4:       return "R4 aux";
      6:       return "R6 zero";
      7:       return "R7 sign";
      8, 9, 10: return "R10 mode";
      11:      return "R8/R9 overflow";
      default: return "R11 constant";
    endcase
  endfunction

  task automatic compare();
    n_chk++;
    if (flags_o !== mdl) begin
      n_bad++;
      for (int b = 0; b < 16; b++)
        if (flags_o[b] !== mdl[b])
          $display("FAIL %s [%s] bit %0d: actual %h expected %h",
                   cur_tag, field_req(b), b, flags_o, mdl);
    end
  endtask

  // behavioural reference: builds the ALU result itself and predicts the word
  task automatic step(string tag, bit upd, int op, bit w, int a, int b,
                      int upper, int s, int c);
    int width, mask, half, am, bm, r, co, sa, sb, sr;
    bit af, of, cf;
    @(negedge clk);
    compare();
    cur_tag = tag;
    width = w ? 16 : 8;
    mask  = (1 << width) - 1;
    half  = 1 << (width - 1);
    am = a & mask;
    bm = b & mask;
    af = mdl[4];
    of = 0;
    cf = 0;
    co = 0;
    if (op == 0) begin
      r  = am + bm;
      co = (r >> width) & 1;
      af = ((a & 15) + (b & 15)) > 15;
    end else if (op == 1) begin
      r  = am - bm;
      co = (am < bm) ? 1 : 0;
      af = (a & 15) < (b & 15);
    end else begin
      r  = (am ^ bm) | (am & 'h0F0F);
      co = upper & 1;
    end
    r = r & mask;
    if (op < 2) begin
      sa = (am >= half) ? am - (1 << width) : am;
      sb = (bm >= half) ? bm - (1 << width) : bm;
      sr = (op == 0) ? sa + sb : sa - sb;
      of = (sr > half - 1) || (sr < -half);
      cf = co[0];
    end
    if (!w) r = r | ((upper & 'hFF) << 8);
    upd_en  = upd;
    op_cls  = op[1:0];
    wide    = w;
    opa     = a[15:0];
    opb     = b[15:0];
    res     = r[15:0];
    cout    = co[0];
    ctl_set = s[2:0];
    ctl_clr = c[2:0];
    if (upd) begin
      mdl[0]  = cf;
      mdl[11] = of;
      mdl[4]  = af;
      mdl[2]  = ($countones(r & 'hFF) % 2) == 0;
      mdl[6]  = (r & mask) == 0;
      mdl[7]  = (r >> (width - 1)) & 1;
    end
    for (int i = 0; i < 3; i++) begin
      if (c[i])      mdl[8 + i] = 1'b0;
      else if (s[i]) mdl[8 + i] = 1'b1;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; upd_en = 0; op_cls = 0; wide = 0; opa = 0; opb = 0;
    res = 0; cout = 0; ctl_set = 0; ctl_clr = 0;
    mdl = 16'h0002;
    cur_tag = "R1 reset";
    repeat (3) @(negedge clk);
    compare();                           // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare();                           // R1 after release

    step("R8 byte 7F+1", 1, 0, 0, 'h7F, 'h01, 'hA5, 0, 0);
    step("R3 word FFFF+1", 1, 0, 1, 'hFFFF, 'h0001, 0, 0, 0);
    step("R6 byte zero upper junk", 1, 0, 0, 'h12FF, 'h0001, 'h5A, 0, 0);
    step("R7 byte sign", 1, 0, 0, 'h0040, 'h0040, 'hFF, 0, 0);
    step("R3 word borrow", 1, 1, 1, 'h0000, 'h0001, 0, 0, 0);
    step("R8 word 8000-1", 1, 1, 1, 'h8000, 'h0001, 0, 0, 0);
    step("R4 aux borrow", 1, 1, 0, 'h0010, 'h0001, 0, 0, 0);
    step("R9 logic keeps aux", 1, 2, 1, 'h8F00, 'h7000, 1, 0, 0);
    step("R9 logic alt code", 1, 3, 0, 'h00F3, 'h0081, 1, 0, 0);
    step("R5 parity word", 1, 0, 1, 'h0100, 'h0003, 0, 0, 0);
    step("R2 idle hold", 0, 0, 1, 'hFFFF, 'hFFFF, 0, 0, 0);
    step("R10 set all", 0, 1, 1, 'h1234, 'h4321, 0, 7, 0);
    step("R10 clear wins", 0, 0, 0, 0, 0, 0, 3, 1);
    step("R10 hold", 1, 0, 1, 'h7FFF, 'h0001, 0, 0, 0);
    step("R10 clear", 0, 0, 0, 0, 0, 0, 0, 6);
    step("R11 constants", 1, 2, 1, 'hFFFF, 'hFFFF, 0, 0, 0);

    for (int k = 0; k < 600; k++)
      step("R2-mix random", ($urandom % 4) != 0, $urandom % 4, $urandom % 2,
           $urandom % 65536, $urandom % 65536, $urandom % 256,
           $urandom % 8, (($urandom % 3) == 0) ? $urandom % 8 : 0);

    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule